// File: doc/BRIEF.md
# Parallel EEPROM Byte-Write Sequencer

This block sits on the host side of a byte-wide parallel EEPROM. It takes one write request at a time over a valid/ready handshake. Each request carries a 13-bit address, an 8-bit data byte and a completion-mode bit. The block produces the chip-enable, output-enable and write-enable strobes. The setup, write-pulse and hold phases each last a number of clock cycles set by configuration inputs. After the strobe sequence, the block waits for the device's internal programming to finish.

Completion is found in one of two ways, chosen per request by the mode bit:

- **Polling mode:** the block repeatedly reads back the written address until the most significant data bit matches the byte that was written.
- **Ready/busy mode:** the block watches an open-drain ready line after synchronising it.

Once the write has completed, one final read checks the whole byte. The block then reports one of three outcomes: success, a verify mismatch, or a timeout if the device never completes. The outcome flags stay valid until the next request is accepted.

Top module: `eeprom_wr_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. The cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `req_ready` is low, and it stays low until a result is posted. `res_valid` and the result flags stay unchanged until the next acceptance.
- R2: For each write, the strobes run in three phases, where max(x,1) means a programmed count of zero is treated as one:
  - Setup: `mem_ce_n` low with `mem_oe_n` and `mem_we_n` high, for max(`cfg_setup`,1) cycles.
  - Write pulse: `mem_we_n` low (with CE low, OE high) for max(`cfg_pulse`,1) cycles.
  - Hold: CE low with WE and OE high for max(`cfg_hold`,1) cycles, after which CE returns high.
- R3: `mem_addr` and `mem_dout` hold the requested address and data without change while WE is low and through the cycle in which WE rises. `mem_dout_en` is high throughout setup, write pulse and hold.
- R4: With `req_mode`=0 (polling), the block issues read cycles (CE and OE low, WE high, `mem_dout_en` low), each lasting max(`cfg_pulse`,1) cycles. It stops polling once bit 7 of the byte read equals bit 7 of the byte written.
- R5: Before every read cycle, CE and OE are both high for at least one cycle, so successive reads are separated.
- R6: With `req_mode`=1 (ready/busy):
  - `mem_rdy` is treated as a pulled-up open-drain line: low means busy, high means done.
  - It passes through a 2-stage synchroniser.
  - It is ignored for 3 cycles after the hold phase.
  - No read is issued before completion, so exactly one read (the verify read) occurs per successful write.
- R7: If completion is not seen within `TIMEOUT_CYC` cycles after the hold phase, the result is posted with `res_timeout`=1 and no verify read is made. The default `TIMEOUT_CYC` is 12000 cycles, which is 240 µs at 50 MHz and so above a 200 µs worst-case write time.
- R8: After completion, one read of the written address is compared with the full written byte. The result is `res_ok`=1 on a match and `res_verify_err`=1 on a mismatch.
- R9: At most one of `res_ok`, `res_timeout` and `res_verify_err` is high at any time. While `res_valid` is high, exactly one of them is high.
- R10: During and after reset:
  - CE, OE and WE are high.
  - `mem_dout_en` is low.
  - `req_ready` is high.
  - `res_valid` and all result flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_addr | input | 13 | Byte address to write |
| req_data | input | 8 | Byte to write |
| req_mode | input | 1 | 0 = poll bit 7, 1 = ready/busy line |
| cfg_setup | input | 8 | Setup phase length in cycles (0 treated as 1) |
| cfg_pulse | input | 8 | Write pulse and read cycle length (0 treated as 1) |
| cfg_hold | input | 8 | Hold phase length in cycles (0 treated as 1) |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 13 | Address to the device |
| mem_dout | output | 8 | Data driven to the device |
| mem_dout_en | output | 1 | High while the host drives the data bus |
| mem_din | input | 8 | Data read from the device |
| mem_rdy | input | 1 | Open-drain ready/busy line, low = busy |
| res_valid | output | 1 | Result of the last request is valid |
| res_ok | output | 1 | Write completed and verified |
| res_timeout | output | 1 | Write never completed |
| res_verify_err | output | 1 | Final read differed from the written byte |

## Verification
Some behaviours are checked by assertions on every cycle:

- the strobe relations, meaning WE low only under CE low with OE high, and the data bus released whenever OE is low;
- address and data stability through the WE pulse;
- the idle gap before every read;
- the drop of `req_ready` after acceptance;
- the exclusivity and persistence of result flags;
- the bound on the timeout counter.

Other behaviours can only be shown by the bench's scenarios against a device model:

- the exact setup, pulse and hold lengths;
- that polling really ends on a bit-7 match;
- that ready/busy mode issues no read before completion;
- the verify-mismatch and timeout outcomes.

// File: rtl/eews_pkg.sv
package eews_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WE_LOW,
    ST_HOLD,
    ST_WAIT,
    ST_POLL_READ,
    ST_CHECK,
    ST_VFY_READ,
    ST_VFY_CHECK,
    ST_DONE,
    ST_ERROR
  } seq_state_e;

  // Strobe pattern decoded from the state
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic drive;
  } strobe_t;

  function automatic strobe_t strobes_for(input seq_state_e st);
    strobe_t s;
    s = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    case (st)
      ST_SETUP, ST_HOLD: begin s.ce_n = 1'b0; s.drive = 1'b1; end
      ST_WE_LOW:         begin s.ce_n = 1'b0; s.we_n = 1'b0; s.drive = 1'b1; end
      ST_POLL_READ,
      ST_VFY_READ:       begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
      default:           ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/eews_phase_timer.sv
module eews_phase_timer #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign last = (cnt <= W'(1));

  AST_TIMER_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> load_val != '0); // R2
endmodule

// File: rtl/eews_rdy_sync.sv
module eews_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], line_in};
  end

  assign line_sync = sh[STAGES-1];
endmodule

// File: rtl/eews_timeout.sv
module eews_timeout #(
  parameter int LIMIT = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cnt <= '0;
    else if (clr)                         cnt <= '0;
    else if (run && cnt < CW'(LIMIT))     cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= CW'(LIMIT));

  AST_TMO_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT)); // R7
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
  import eews_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int CFG_W       = 8,
  parameter int TIMEOUT_CYC = 12000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_mode,
  input  logic [CFG_W-1:0]  cfg_setup,
  input  logic [CFG_W-1:0]  cfg_pulse,
  input  logic [CFG_W-1:0]  cfg_hold,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  input  logic              mem_rdy,
  output logic              res_valid,
  output logic              res_ok,
  output logic              res_timeout,
  output logic              res_verify_err
);
  localparam int TW    = CFG_W + 1;
  localparam int BLANK = SYNC_STAGES + 1;

  function automatic logic [TW-1:0] phase_len(input logic [CFG_W-1:0] v);
    return (v == '0) ? TW'(1) : TW'(v);
  endfunction

  function automatic logic poll_complete(input logic [DATA_W-1:0] rd,
                                         input logic [DATA_W-1:0] wr);
    return rd[DATA_W-1] == wr[DATA_W-1];
  endfunction

  seq_state_e        state, nxt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, rd_q;
  logic              mode_q;
  logic [TW-1:0]     load_val;
  strobe_t           stb;

  // Named internal events
  logic accept, phase_last, rdy_sync, tmo_hit, write_complete, tmo_run;

  assign accept = req_valid && req_ready;

  eews_phase_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(nxt != state), .load_val(load_val),
    .last(phase_last));

  eews_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(mem_rdy), .line_sync(rdy_sync));

  assign tmo_run = (state == ST_WAIT) || (state == ST_POLL_READ) || (state == ST_CHECK);

  eews_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clr(accept), .run(tmo_run), .expired(tmo_hit));

  assign write_complete = mode_q ? rdy_sync : poll_complete(rd_q, data_q);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:      if (req_valid) nxt = ST_SETUP;
      ST_SETUP:     if (phase_last) nxt = ST_WE_LOW;
      ST_WE_LOW:    if (phase_last) nxt = ST_HOLD;
      ST_HOLD:      if (phase_last) nxt = ST_WAIT;
      ST_WAIT:      if (phase_last) nxt = mode_q ? ST_CHECK : ST_POLL_READ;
      ST_POLL_READ: if (phase_last) nxt = ST_CHECK;
      ST_CHECK: begin
        if (write_complete) nxt = ST_VFY_READ;
        else if (tmo_hit)   nxt = ST_ERROR;
        else if (!mode_q)   nxt = ST_POLL_READ;
      end
      ST_VFY_READ:  if (phase_last) nxt = ST_VFY_CHECK;
      ST_VFY_CHECK: nxt = ST_DONE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      ST_SETUP:     load_val = phase_len(cfg_setup);
      ST_WE_LOW:    load_val = phase_len(cfg_pulse);
      ST_HOLD:      load_val = phase_len(cfg_hold);
      ST_WAIT:      load_val = mode_q ? TW'(BLANK) : TW'(1);
      ST_POLL_READ,
      ST_VFY_READ:  load_val = phase_len(cfg_pulse);
      default:      load_val = TW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      addr_q         <= '0;
      data_q         <= '0;
      rd_q           <= '0;
      mode_q         <= 1'b0;
      res_valid      <= 1'b0;
      res_ok         <= 1'b0;
      res_timeout    <= 1'b0;
      res_verify_err <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        addr_q         <= req_addr;
        data_q         <= req_data;
        mode_q         <= req_mode;
        res_valid      <= 1'b0;
        res_ok         <= 1'b0;
        res_timeout    <= 1'b0;
        res_verify_err <= 1'b0;
      end
      if ((state == ST_POLL_READ || state == ST_VFY_READ) && phase_last)
        rd_q <= mem_din;
      if (state == ST_VFY_CHECK) begin
        res_valid      <= 1'b1;
        res_ok         <= (rd_q == data_q);
        res_verify_err <= (rd_q != data_q);
      end
      if (state == ST_CHECK && nxt == ST_ERROR) begin
        res_valid   <= 1'b1;
        res_timeout <= 1'b1;
      end
    end
  end

  assign stb         = strobes_for(state);
  assign mem_ce_n    = stb.ce_n;
  assign mem_oe_n    = stb.oe_n;
  assign mem_we_n    = stb.we_n;
  assign mem_dout_en = stb.drive;
  assign mem_addr    = addr_q;
  assign mem_dout    = data_q;
  assign req_ready   = (state == ST_IDLE);

  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n)); // R2
  AST_ADDR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> ($stable(mem_addr) && $stable(mem_dout) && mem_dout_en)); // R3
  AST_DATA_THROUGH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dout_en && $stable(mem_dout) && $stable(mem_addr))); // R3
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_dout_en && mem_we_n && !mem_ce_n)); // R4
  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> $past(mem_ce_n)); // R5
  AST_RB_NO_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !req_ready) |-> (state != ST_POLL_READ)); // R6
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R1
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !accept) |=> (res_valid && $stable({res_ok, res_timeout, res_verify_err}))); // R1
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_ok, res_timeout, res_verify_err})); // R9
  AST_VALID_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($countones({res_ok, res_timeout, res_verify_err}) == 1)); // R9
endmodule

// File: tb/eeprom_wr_seq_tb.sv
`timescale 1ns/1ps
module eeprom_wr_seq_tb_top;
  localparam int TMO = 12000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_mode = 1'b0;
  logic        req_ready;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic [7:0]  cfg_setup = 8'd1, cfg_pulse = 8'd1, cfg_hold = 8'd1;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en, mem_rdy;
  logic [12:0] mem_addr;
  logic [7:0]  mem_dout, mem_din;
  logic        res_valid, res_ok, res_timeout, res_verify_err;

  eeprom_wr_seq #(.TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_mode(req_mode),
    .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
    .mem_din(mem_din), .mem_rdy(mem_rdy), .res_valid(res_valid), .res_ok(res_ok),
    .res_timeout(res_timeout), .res_verify_err(res_verify_err));

  // ---------------- device model ----------------
  logic [7:0]  mem_arr [64];
  logic        wr_pend = 1'b0;
  logic [12:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  int          busy_cnt = 0;
  int          busy_len = 1;
  logic        corrupt = 1'b0, stuck = 1'b0;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      if (!wr_pend) m_addr <= mem_addr;
      wr_pend <= 1'b1;
    end else if (wr_pend && mem_we_n) begin
      wr_pend <= 1'b0;
      m_data  <= mem_dout_en ? mem_dout : 8'hxx;
      mem_arr[m_addr[5:0]] <= mem_dout_en ? (corrupt ? mem_dout ^ 8'h01 : mem_dout) : 8'hxx;
      busy_cnt <= busy_len;
    end else if (busy_cnt > 0 && !stuck) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  assign mem_rdy = (busy_cnt == 0);
  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_din = (busy_cnt != 0 && mem_addr == m_addr) ? {~m_data[7], m_data[6:0]}
                                                      : mem_arr[mem_addr[5:0]];
    else
      mem_din = 8'h00;
  end

  // ---------------- strobe monitor ----------------
  int   su, pw, ho, reads, gap_bad;
  logic seen_we, prev_ce_n = 1'b1, prev_oe_n = 1'b1;
  always @(negedge clk) begin
    if (req_valid && req_ready) begin
      su = 0; pw = 0; ho = 0; reads = 0; gap_bad = 0; seen_we = 1'b0;
    end else begin
      if (!mem_ce_n && mem_we_n && mem_oe_n && !seen_we) su++;
      if (!mem_we_n) begin pw++; seen_we = 1'b1; end
      if (seen_we && mem_we_n && !mem_ce_n && mem_oe_n) ho++;
      if (!mem_oe_n && prev_oe_n) begin
        reads++;
        if (!prev_ce_n) gap_bad++;
      end
    end
    prev_ce_n = mem_ce_n;
    prev_oe_n = mem_oe_n;
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  typedef struct packed {
    logic        mode;
    logic [7:0]  s, p, h;
    logic [12:0] addr;
    logic [7:0]  data;
    logic [15:0] busy;
    logic [1:0]  fault;   // 0 none, 1 corrupt store, 2 stuck busy
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd1, 8'd1, 8'd1, 13'h0005, 8'hA5, 16'd20, 2'd0},
    '{1'b0, 8'd3, 8'd4, 8'd2, 13'h1FFF, 8'h3C, 16'd50, 2'd0},
    '{1'b1, 8'd2, 8'd2, 8'd3, 13'h0000, 8'hFF, 16'd30, 2'd0},
    '{1'b0, 8'd0, 8'd0, 8'd0, 13'h0AAA, 8'h80, 16'd5,  2'd0},
    '{1'b1, 8'd5, 8'd1, 8'd1, 13'h1555, 8'h01, 16'd1,  2'd0},
    '{1'b0, 8'd2, 8'd2, 8'd2, 13'h0010, 8'h7E, 16'd25, 2'd1},
    '{1'b1, 8'd1, 8'd3, 8'd1, 13'h0011, 8'hC3, 16'd10, 2'd1}
  };

  task automatic run_txn(input vec_t v);
    int n = 0;
    busy_len = int'(v.busy);
    corrupt  = (v.fault == 2'd1);
    stuck    = (v.fault == 2'd2);
    cfg_setup = v.s; cfg_pulse = v.p; cfg_hold = v.h;
    @(posedge clk); #2;
    req_valid = 1'b1; req_mode = v.mode; req_addr = v.addr; req_data = v.data;
    @(posedge clk); #2;
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1", "ready after accept", req_ready, 0);
    while (!res_valid && n < 3 * TMO) begin @(negedge clk); n++; end

    if (v.fault == 2'd2) begin
      chk(res_timeout == 1'b1, "R7", "timeout flag", res_timeout, 1);
      chk(n >= TMO, "R7", "cycles before timeout", n, TMO);
      chk(res_ok == 1'b0 && res_verify_err == 1'b0, "R9", "other flags on timeout",
          {res_ok, res_verify_err}, 0);
    end else begin
      chk(res_ok == (v.fault == 2'd0), "R8", "ok flag", res_ok, int'(v.fault == 2'd0));
      chk(res_verify_err == (v.fault == 2'd1), "R8", "verify_err flag",
          res_verify_err, int'(v.fault == 2'd1));
      chk(res_timeout == 1'b0, "R9", "no timeout", res_timeout, 0);
      chk(mem_arr[v.addr[5:0]] === (corrupt ? v.data ^ 8'h01 : v.data), "R3",
          "byte stored", mem_arr[v.addr[5:0]], v.data);
      chk(m_addr == v.addr, "R3", "address at WE", m_addr, v.addr);
      if (v.mode) chk(reads == 1, "R6", "reads in ready/busy mode", reads, 1);
      else        chk(reads >= 2, "R4", "poll plus verify reads", reads, 2);
    end
    chk(su == eff(v.s), "R2", "setup cycles", su, eff(v.s));
    chk(pw == eff(v.p), "R2", "WE low cycles", pw, eff(v.p));
    chk(ho == eff(v.h), "R2", "hold cycles", ho, eff(v.h));
    chk(gap_bad == 0, "R5", "reads without idle gap", gap_bad, 0);
    repeat (8) @(negedge clk);
    chk(res_valid == 1'b1 && req_ready == 1'b1, "R1", "result held, ready back",
        {res_valid, req_ready}, 3);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem_arr[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R10", "strobes in reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dout_en && req_ready && !res_valid, "R10", "bus/ready/result in reset",
        {mem_dout_en, req_ready, res_valid}, 2);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_txn(VECS[i]);

    // R10: reset in the middle of a write
    cfg_setup = 8'd2; cfg_pulse = 8'd6; cfg_hold = 8'd2; busy_len = 10;
    corrupt = 1'b0; stuck = 1'b0;
    @(posedge clk); #2 req_valid = 1'b1; req_mode = 1'b0; req_addr = 13'h0020; req_data = 8'h55;
    @(posedge clk); #2 req_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dout_en, "R10", "strobes after mid reset",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en}, 14);
    chk(req_ready && !res_valid && !res_ok, "R10", "ready/result after mid reset",
        {req_ready, res_valid, res_ok}, 4);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R7: device never finishes, in both completion modes
    run_txn('{1'b0, 8'd1, 8'd2, 8'd1, 13'h0030, 8'h9A, 16'd1, 2'd2});
    run_txn('{1'b1, 8'd1, 8'd1, 8'd1, 13'h0031, 8'h12, 16'd1, 2'd2});

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule